// File: doc/BRIEF.md
# Dual-Channel Power-Good Monitor

This block produces a single power-good flag for a pair of converter channels. Each channel reports three things: whether its output sits inside its regulation window, whether its soft-start has finished, and its enable level. A fault supervisor also supplies an overvoltage-latch indication. Power-good is raised only when both channels have finished soft-start and both are in the window. It is removed when a window fault lasts long enough to be real.

A brief excursion out of the window is filtered by a consecutive-cycle qualifier. The qualifier restarts whenever both windows come back in range. Two conditions bypass the filter. The first is a window fault while both enables are low. The second is an overvoltage latch, which clears power-good in the same cycle and holds it low until the next power-on reset. The window comparators and the open-drain pin driver are outside the block.

Top module: `pg_share_monitor`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `pgood_o` is 0.
- R2: While either bit of `ss_done_i` is 0 at a clock edge, `pgood_o` is 0 after that edge.
- R3: When, at a clock edge, `pgood_o` is 0, every bit of `win_ok_i` and `ss_done_i` is 1, and no overvoltage latch has been seen since reset, `pgood_o` is 1 after that edge.
- R4: A window fault (any bit of `win_ok_i` at 0) lasting for fewer than 3 consecutive clock edges leaves `pgood_o` at 1.
- R5: A window fault present at 3 consecutive clock edges makes `pgood_o` 0 after the third edge.
- R6: The fault count restarts when both `win_ok_i` bits are 1 at an edge, so two short faults separated by one in-window cycle do not clear `pgood_o`.
- R7: `ov_latch_i` at 1 makes `pgood_o` 0 in the same cycle, and `pgood_o` stays 0 from then until the next reset, whatever the other inputs do.
- R8: A window fault seen at an edge where both bits of `en_i` are 0 makes `pgood_o` 0 after that single edge.
- R9: A fault on either channel alone (bit 0 or bit 1 of `win_ok_i`) qualifies for removal of `pgood_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| win_ok_i | input | NUM_CH | Per-channel regulation-window flag, 1 = inside the window |
| ss_done_i | input | NUM_CH | Per-channel soft-start complete, 1 = complete |
| en_i | input | NUM_CH | Per-channel enable level, 1 = enabled |
| ov_latch_i | input | 1 | Overvoltage latch from the fault supervisor, 1 = tripped |
| pgood_o | output | 1 | Shared power-good, 1 = good |

## Verification
The hardest state to reach is a fault count that has advanced part way, is reset by a single in-window cycle, and then faces a new fault. A sequence that only counts to three cannot tell a restarting counter from one that keeps accumulating. The bench holds one channel out of the window for two edges, returns it for exactly one edge, and then repeats the two-edge fault, so that pgood_o must stay high. Only after that does it apply a full three-edge fault. The sticky overvoltage hold is reached by pulsing the latch input once and then restoring every other input to its good value for several cycles.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef struct packed {
    logic win_all;   // every channel inside its window
    logic ss_all;    // every channel past soft-start
    logic fault;     // at least one channel out of window
    logic dis_fault; // fault while all enables are low
  } pg_stat_t;
endpackage

// File: rtl/pg_qualify.sv
module pg_qualify #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] win_ok_i,
  input  logic [NUM_CH-1:0] ss_done_i,
  input  logic [NUM_CH-1:0] en_i,
  output pg_pkg::pg_stat_t  stat_o
);
  logic [NUM_CH-1:0] bad_ch;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign bad_ch[c] = ~win_ok_i[c];
  end

  always_comb begin
    stat_o.fault     = |bad_ch;
    stat_o.win_all   = ~stat_o.fault;
    stat_o.ss_all    = &ss_done_i;
    stat_o.dis_fault = stat_o.fault & ~(|en_i);
  end
endmodule

// File: rtl/pg_deglitch.sv
module pg_deglitch #(
  parameter int DEGLITCH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic fault_i,
  output logic expire_o
);
  localparam int CNT_W = (DEGLITCH > 1) ? $clog2(DEGLITCH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEGLITCH - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!armed_i || !fault_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = armed_i & fault_i & (cnt_q == LAST);
endmodule

// File: rtl/pg_ov_hold.sv
module pg_ov_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ov_latch_i,
  output logic hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_o <= 1'b0;
    else if (ov_latch_i) hold_o <= 1'b1;
  end
endmodule

// File: rtl/pg_share_monitor.sv
module pg_share_monitor #(
  parameter int NUM_CH   = 2,
  parameter int DEGLITCH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] win_ok_i,
  input  logic [NUM_CH-1:0] ss_done_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              ov_latch_i,
  output logic              pgood_o
);
  pg_pkg::pg_stat_t stat;
  logic pg_q;
  logic expire;
  logic ov_hold;
  logic ov_any;

  pg_qualify #(.NUM_CH(NUM_CH)) u_qual (
    .win_ok_i (win_ok_i),
    .ss_done_i(ss_done_i),
    .en_i     (en_i),
    .stat_o   (stat)
  );

  pg_deglitch #(.DEGLITCH(DEGLITCH)) u_dgl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (pg_q),
    .fault_i (stat.fault),
    .expire_o(expire)
  );

  pg_ov_hold u_ov (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ov_latch_i(ov_latch_i),
    .hold_o    (ov_hold)
  );

  assign ov_any = ov_hold | ov_latch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q <= 1'b0;
    end else if (ov_any || !stat.ss_all || stat.dis_fault || expire) begin
      pg_q <= 1'b0;
    end else if (stat.win_all) begin
      pg_q <= 1'b1;
    end
  end

  // overvoltage gates the output combinationally
  assign pgood_o = pg_q & ~ov_any;
endmodule

// File: rtl/pg_share_monitor_chk.sv
module pg_share_monitor_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] win_ok_i,
  input logic [NUM_CH-1:0] ss_done_i,
  input logic [NUM_CH-1:0] en_i,
  input logic              ov_latch_i,
  input logic              pgood_o
);
  logic ov_seen_q;
  logic flt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ov_seen_q <= 1'b0;
    else if (ov_latch_i) ov_seen_q <= 1'b1;
  end

  assign flt = ~(&win_ok_i);

  // R1
  always_comb begin
    if (!rst_ni) reset_low_chk: assert (pgood_o == 1'b0 || $isunknown(pgood_o));
  end

  // R2
  no_early_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&ss_done_i) |=> !pgood_o);

  // R3
  assert_on_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pgood_o && (&win_ok_i) && (&ss_done_i) && !ov_latch_i && !ov_seen_q)
    |=> (pgood_o || ov_latch_i));

  // R5
  three_fault_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt && $past(flt) && $past(flt, 2)) |=> !pgood_o);

  // R7
  ov_now_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_latch_i |-> !pgood_o);

  // R7
  ov_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_seen_q |-> !pgood_o);

  // R8
  disabled_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt && !(|en_i)) |=> !pgood_o);
endmodule

bind pg_share_monitor pg_share_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .win_ok_i  (win_ok_i),
  .ss_done_i (ss_done_i),
  .en_i      (en_i),
  .ov_latch_i(ov_latch_i),
  .pgood_o   (pgood_o)
);

// File: tb/pg_share_monitor_bench.sv
module pg_share_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] win = 2'b00;
  logic [1:0] ss = 2'b00;
  logic [1:0] en = 2'b00;
  logic       ov = 1'b0;
  logic       pgood;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pg_share_monitor u_pg_share_monitor (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .win_ok_i  (win),
    .ss_done_i (ss),
    .en_i      (en),
    .ov_latch_i(ov),
    .pgood_o   (pgood)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    n_cmp++;
    if (pgood !== exp) begin
      n_bad++;
      $display("FAIL %s: pgood_o=%b expected %b at %0t", req, pgood, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    win = 2'b11; ss = 2'b00; en = 2'b11; ov = 1'b0;
    do_reset();
    chk(1'b0, "R1");
  endtask

  task automatic t_startup();
    ss = 2'b01; win = 2'b11;
    tick(3);
    chk(1'b0, "R2 one ss pending");
    ss = 2'b11;
    tick(1);
    chk(1'b1, "R3 first ready edge");
  endtask

  task automatic t_glitch();
    win = 2'b10; tick(2);
    chk(1'b1, "R4 two-cycle fault");
    win = 2'b11; tick(1);
    win = 2'b10; tick(2);
    chk(1'b1, "R6 count restarted");
    win = 2'b11; tick(1);
    win = 2'b10; tick(2);
    chk(1'b1, "R5 before third edge");
    tick(1);
    chk(1'b0, "R5 after third edge");
    win = 2'b11; tick(1);
    chk(1'b1, "R3 reassert");
  endtask

  task automatic t_other_ch();
    win = 2'b01; tick(3);
    chk(1'b0, "R9 channel 1 fault");
    win = 2'b11; tick(1);
    chk(1'b1, "R3 after ch1");
  endtask

  task automatic t_disabled();
    en = 2'b00; tick(2);
    chk(1'b1, "R8 disabled in window");
    win = 2'b01; tick(1);
    chk(1'b0, "R8 disabled fault");
    en = 2'b11; win = 2'b11; tick(1);
    chk(1'b1, "R3 after disable");
  endtask

  task automatic t_ss_drop();
    ss = 2'b10; tick(1);
    chk(1'b0, "R2 ss dropped");
    ss = 2'b11; tick(1);
    chk(1'b1, "R3 after ss");
  endtask

  task automatic t_ov();
    #1 ov = 1'b1;
    #0.5;
    chk(1'b0, "R7 immediate");
    tick(1);
    ov = 1'b0;
    tick(5);
    chk(1'b0, "R7 held");
    do_reset();
    chk(1'b1, "R7 cleared by reset");
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_startup();
    t_glitch();
    t_other_ch();
    t_disabled();
    t_ss_drop();
    t_ov();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule